// File: doc/BRIEF.md
# Dual-Address DMA Channel Engine

A bus-master DMA engine with several channels. Each channel owns a source pointer, a destination pointer, a unit count and a small control word. Once a channel is started with a non-zero count, the engine asks the processor core for the bus. It issues no bus cycle until the core acknowledges. It then moves one unit at a time: a read from the source, with the data held in an internal holding register, and then a write of that data to the destination. After each unit both pointers advance and the count drops by one. When the count runs out, the channel's start bit clears by itself.

The control word picks the kind of ownership a channel asks for. The plain kind lets the core ask for the bus back. The snooping kind lets the core watch the engine's data bus, and here a request to give the bus back is ignored. A per-channel yield bit decides whether a plain-mode channel gives the bus up when the core asks. It only does so after a whole read/write pair, so a held data word is never dropped. When several channels are pending, the lowest-numbered one wins. Channels change only between complete pairs. The per-channel acknowledge lines mark bus cycles whose target the control word flags as an I/O device.

Top module: `dma_dual_engine`

## Requirements
- R1: No memory cycle starts until `bus_ack` has been seen high with `bus_req` raised; with `bus_ack` held low the engine keeps `bus_req` high and issues nothing.
- R2: While `bus_req` is high, `snoop_req` equals control bit 1 of the channel being served (1 = snooping kind, 0 = plain kind) and stays constant for the whole ownership period.
- R3: With control bit 1 = 0 and yield bit (control bit 2) = 1, a release request on `rel_req` ends ownership at the next read/write pair boundary: `bus_req` drops after the write completes.
- R4: A release request has no effect when the served channel is in the snooping kind or its yield bit is 0; all units are moved in one ownership period.
- R5: Every unit is a read (`mem_we`=0) of the source pointer followed by a write (`mem_we`=1) to the destination pointer, and the write data equals the data returned by that read.
- R6: Registers are selected by `cfg_sel`: 0 source pointer, 1 destination pointer, 2 unit count, 3 control word. After each unit both pointers grow by ADDR_STEP and the count drops by one. A channel moves exactly its count of units, and its start bit (control bit 0) is then clear, so a later count write alone starts nothing.
- R7: `dack[n]` is high during a read of channel n when its control bit 3 is set, and during a write of channel n when its control bit 4 is set, and is low otherwise; at most one bit is set.
- R8: Out of reset, and once no channel is pending, `bus_req`, `mem_valid` and `dack` are low.
- R9: The pending channel with the lowest number is served next, and the served channel changes only after a write completes, never between a read and its write.
- R10: A channel started with a count of zero issues no bus request and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Write data; control bits: 0 start, 1 snooping kind, 2 yield, 3 source is I/O, 4 destination is I/O |
| bus_req | output | 1 | Bus ownership request to the core |
| snoop_req | output | 1 | Requested ownership is the snooping kind |
| bus_ack | input | 1 | Core grants the bus |
| rel_req | input | 1 | Core asks for the bus back |
| mem_valid | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | AW | Cycle address |
| mem_wdata | output | DW | Write data from the holding register |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Cycle completes on this clock |
| dack | output | NCH | Per-channel I/O acknowledge |

## Verification
Each channel is swept over counts 0 to 3 and all four I/O flag combinations. Ready is either always high or stalled every third cycle, and the ownership kind alternates. Together these separate count handling, pointer stepping, acknowledge placement and the zero-count case. The release request is held high under three setups: plain with yield, plain without yield, and snooping with yield. Only the first may split the transfer into one ownership per unit. A second channel started while the first waits on a stalled read shows whether priority is taken only at pair boundaries. Holding the acknowledge low shows that no cycle leaks out before the grant.

// File: rtl/dma_dual_engine.sv
module dma_dual_engine #(
  parameter int NCH       = 4,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int ADDR_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [((NCH>1)?$clog2(NCH):1)-1:0] cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic             bus_req,
  output logic             snoop_req,
  input  logic             bus_ack,
  input  logic             rel_req,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  output logic [NCH-1:0]   dack
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RD, S_WR} state_t;

  state_t         state;
  logic [CHW-1:0] cur_q, pick;
  logic [DW-1:0]  dhr_q;
  logic           rel_seen_q;

  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic [NCH-1:0] go_q, snp_q, yld_q, sio_q, dio_q;

  logic [NCH-1:0] pend, pend_after, cur_oh;
  logic           rd_done, wr_done, last_unit, yield_now, kind_change;

  assign rd_done   = (state == S_RD) && mem_ready;
  assign wr_done   = (state == S_WR) && mem_ready;
  assign cur_oh    = NCH'(1) << cur_q;
  assign last_unit = cnt_q[cur_q] == CW'(1);

  always_comb begin
    for (int i = 0; i < NCH; i++) pend[i] = go_q[i] && (cnt_q[i] != '0);
  end

  assign pend_after = pend & ~((wr_done && last_unit) ? cur_oh : '0);

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) if (pend_after[i]) pick = CHW'(i);
  end

  assign yield_now   = (rel_req || rel_seen_q) && !snp_q[cur_q] && yld_q[cur_q];
  assign kind_change = snp_q[pick] != snp_q[cur_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      go_q  <= '0;
      snp_q <= '0;
      yld_q <= '0;
      sio_q <= '0;
      dio_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (cfg_we && cfg_ch == CHW'(i)) begin
          case (cfg_sel)
            2'd0: src_q[i] <= cfg_wdata;
            2'd1: dst_q[i] <= cfg_wdata;
            2'd2: cnt_q[i] <= cfg_wdata[CW-1:0];
            default: begin
              go_q[i]  <= cfg_wdata[0];
              snp_q[i] <= cfg_wdata[1];
              yld_q[i] <= cfg_wdata[2];
              sio_q[i] <= cfg_wdata[3];
              dio_q[i] <= cfg_wdata[4];
            end
          endcase
        end else if (cur_q == CHW'(i)) begin
          if (rd_done) src_q[i] <= src_q[i] + AW'(ADDR_STEP);
          if (wr_done) begin
            dst_q[i] <= dst_q[i] + AW'(ADDR_STEP);
            cnt_q[i] <= cnt_q[i] - 1'b1;
            if (cnt_q[i] == CW'(1)) go_q[i] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_q      <= '0;
      dhr_q      <= '0;
      rel_seen_q <= 1'b0;
    end else begin
      rel_seen_q <= (state == S_IDLE) ? 1'b0 : (rel_seen_q || rel_req);
      case (state)
        S_IDLE: if (|pend) begin
          cur_q <= pick;
          state <= S_REQ;
        end
        S_REQ: if (bus_ack) state <= S_RD;
        S_RD: if (mem_ready) begin
          dhr_q <= mem_rdata;
          state <= S_WR;
        end
        default: if (mem_ready) begin
          if (!(|pend_after) || yield_now || kind_change) state <= S_IDLE;
          else begin
            cur_q <= pick;
            state <= S_RD;
          end
        end
      endcase
    end
  end

  assign bus_req   = state != S_IDLE;
  assign snoop_req = bus_req && snp_q[cur_q];
  assign mem_valid = (state == S_RD) || (state == S_WR);
  assign mem_we    = state == S_WR;
  assign mem_addr  = mem_we ? dst_q[cur_q] : src_q[cur_q];
  assign mem_wdata = dhr_q;
  assign dack      = (((state == S_RD) && sio_q[cur_q]) || ((state == S_WR) && dio_q[cur_q]))
                     ? cur_oh : '0;

  assert_ack_before_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(bus_ack));

  assert_kind_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(snoop_req));

  assert_read_feeds_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we && mem_wdata == $past(mem_rdata)));

  assert_cycle_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));

  assert_dack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack) && (dack == '0 || mem_valid));

  assert_no_empty_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REQ) |-> (cnt_q[cur_q] != '0 && go_q[cur_q]));
endmodule

// File: tb/dma_dual_engine_tb.sv
`timescale 1ns/1ps
module dma_dual_engine_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_ch = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic        bus_req, snoop_req, bus_ack = 0, rel_req = 0;
  logic        mem_valid, mem_we, mem_ready = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  dack;

  always #2 clk = ~clk;

  dma_dual_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .snoop_req(snoop_req), .bus_ack(bus_ack),
    .rel_req(rel_req), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .dack(dack));

  assign mem_rdata = mem_addr * 16'd3 + 16'h1234;

  int checks = 0, errors = 0, mchecks = 0, merrs = 0;
  int rd_cnt[4], wr_cnt[4], falls = 0, tick = 0, nlog = 0, wd = 0;
  int log_ch[512];
  logic [15:0] base_src[4], base_dst[4], last_data = 0;
  bit sio_e[4], dio_e[4];
  bit exp_mode = 0, chk_mode = 0, auto_ack = 1, slow = 0, hold = 0;
  bit phase_wr = 0, prev_req = 0, prev_valid = 0;
  int last_ch = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic mcheck(input bit ok, input string tag, input int act, input int exp);
    mchecks++;
    if (!ok) begin merrs++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(negedge clk) begin
    bit nr;
    int ch;
    logic [3:0] ed;
    tick++;
    nr = hold ? 1'b0 : (slow ? (tick % 3 != 0) : 1'b1);
    if (rst_n) begin
      if (prev_req && !bus_req) falls++;
      if (mem_valid && !prev_valid) mcheck(bus_ack === 1'b1, "R1 cycle began without ack", bus_ack, 1);
      if (chk_mode && bus_req) mcheck(snoop_req === exp_mode, "R2 ownership kind", snoop_req, exp_mode);
      if (mem_valid && nr) begin
        ch = int'(mem_addr[13:12]);
        if (!mem_we) begin
          ed = sio_e[ch] ? (4'b1 << ch) : 4'b0;
          mcheck(!phase_wr, "R5 read while write owed", phase_wr, 0);
          mcheck(mem_addr == base_src[ch] + 16'(rd_cnt[ch]), "R6 read address", mem_addr, base_src[ch] + 16'(rd_cnt[ch]));
          mcheck(dack == ed, "R7 dack on read", dack, ed);
          last_ch = ch; last_data = mem_rdata; phase_wr = 1; rd_cnt[ch]++;
        end else begin
          ed = dio_e[ch] ? (4'b1 << ch) : 4'b0;
          mcheck(phase_wr && ch == last_ch, "R9 write not paired with its read", ch, last_ch);
          mcheck(mem_addr == base_dst[ch] + 16'(wr_cnt[ch]), "R6 write address", mem_addr, base_dst[ch] + 16'(wr_cnt[ch]));
          mcheck(mem_wdata == last_data, "R5 write data", mem_wdata, last_data);
          mcheck(dack == ed, "R7 dack on write", dack, ed);
          phase_wr = 0; wr_cnt[ch]++;
          if (nlog < 512) log_ch[nlog] = ch;
          nlog++;
        end
      end
      prev_req = bus_req; prev_valid = mem_valid;
    end
    mem_ready <= nr;
    bus_ack   <= auto_ack && bus_req;
  end

  always @(negedge clk) begin
    wd++;
    if (wd == 150000) begin
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrs + 1);
      $finish;
    end
  end

  task automatic cfg(input int ch, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int n = 0;
    while (quiet < 4 && n < 2000) begin
      @(negedge clk); n++;
      quiet = bus_req ? 0 : quiet + 1;
    end
  endtask

  task automatic setup(input int ch, input int cnt, input int src, input int dst, input int ctrl);
    cfg(ch, 3, 0);
    base_src[ch] = 16'(src) - 16'(rd_cnt[ch]);
    base_dst[ch] = 16'(dst) - 16'(wr_cnt[ch]);
    sio_e[ch] = ctrl[3]; dio_e[ch] = ctrl[4];
    cfg(ch, 0, src); cfg(ch, 1, dst); cfg(ch, 2, cnt); cfg(ch, 3, ctrl);
  endtask

  initial begin
    int w0, f0, n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bus_req == 0 && mem_valid == 0 && dack == 0 && snoop_req == 0,
          "R8 reset state idle", {bus_req, mem_valid, snoop_req}, 0);

    for (int ch = 0; ch < 4; ch++)
      for (int cnt = 0; cnt < 4; cnt++)
        for (int io = 0; io < 4; io++) begin
          bit md;
          md = io[0] ^ cnt[0];
          slow = cnt[1] ^ io[1];
          exp_mode = md; chk_mode = 1;
          w0 = wr_cnt[ch]; f0 = falls;
          setup(ch, cnt, (ch << 12) | (cnt * 16 + io), 16'h8000 | (ch << 12) | (16'h80 + cnt * 16 + io),
                1 | (md << 1) | (io << 3));
          wait_idle();
          check(wr_cnt[ch] - w0 == cnt, "R6 units moved", wr_cnt[ch] - w0, cnt);
          check(falls - f0 == (cnt != 0 ? 1 : 0), "R8 one ownership then release", falls - f0, cnt != 0);
          check(bus_req == 0 && mem_valid == 0, "R8 idle after transfer", bus_req, 0);
          if (cnt == 0) check(falls == f0, "R10 zero count starts nothing", falls - f0, 0);
          if (cnt == 3) begin
            cfg(ch, 2, 2);
            wait_idle();
            check(wr_cnt[ch] - w0 == 3 && falls - f0 == 1, "R6 start bit cleared", wr_cnt[ch] - w0, 3);
          end
        end
    chk_mode = 0; slow = 0;

    slow = 1; rel_req = 1; exp_mode = 0; chk_mode = 1;
    w0 = wr_cnt[0]; f0 = falls;
    setup(0, 4, 16'h0200, 16'h8200, 1 | 4);
    wait_idle();
    check(falls - f0 == 4, "R3 release honoured once per pair", falls - f0, 4);
    check(wr_cnt[0] - w0 == 4, "R3 all units still moved", wr_cnt[0] - w0, 4);

    w0 = wr_cnt[0]; f0 = falls;
    setup(0, 4, 16'h0300, 16'h8300, 1);
    wait_idle();
    check(falls - f0 == 1 && wr_cnt[0] - w0 == 4, "R4 release ignored without yield", falls - f0, 1);

    exp_mode = 1;
    w0 = wr_cnt[1]; f0 = falls;
    setup(1, 4, 16'h1300, 16'h9300, 1 | 2 | 4);
    wait_idle();
    check(falls - f0 == 1 && wr_cnt[1] - w0 == 4, "R4 release ignored in snooping kind", falls - f0, 1);
    rel_req = 0; chk_mode = 0; slow = 0;

    hold = 1;
    setup(1, 2, 16'h1400, 16'h9400, 0);
    cfg(1, 3, 0);
    n0 = nlog;
    setup(2, 2, 16'h2400, 16'h8400 | 16'h2000, 1);
    while (!(mem_valid && !mem_we)) @(negedge clk);
    cfg(1, 3, 1);
    base_src[1] = 16'h1400 - 16'(rd_cnt[1]);
    base_dst[1] = 16'h9400 - 16'(wr_cnt[1]);
    cfg(1, 0, 16'h1400);
    cfg(1, 1, 16'h9400);
    hold = 0;
    wait_idle();
    check(nlog - n0 == 4, "R9 pair count", nlog - n0, 4);
    check(log_ch[n0] == 2 && log_ch[n0+1] == 1 && log_ch[n0+2] == 1 && log_ch[n0+3] == 2,
          "R9 lowest channel after boundary", log_ch[n0+1], 1);

    auto_ack = 0;
    w0 = wr_cnt[3];
    setup(3, 1, 16'h3500, 16'hB500, 1);
    repeat (10) @(negedge clk);
    check(bus_req == 1, "R1 request held awaiting ack", bus_req, 1);
    check(wr_cnt[3] == w0 && !mem_valid, "R1 no cycle before ack", mem_valid, 0);
    auto_ack = 1;
    wait_idle();
    check(wr_cnt[3] - w0 == 1, "R1 transfer after ack", wr_cnt[3] - w0, 1);

    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrs);
    $finish;
  end
endmodule